// File: doc/BRIEF.md
# Serial EEPROM and Calibration DAC Master

This block drives one serial clock and one serial data line that are shared by two kinds of target: a small serial EEPROM that takes 8-bit instructions, and a bank of 8-bit calibration DACs that take a 4-bit channel and an 8-bit value. A host presents one command at a time with a one-cycle valid strobe. The block runs the whole exchange on the wire and reports the byte read back, a busy flag and an error flag.

The EEPROM side covers three commands: read a byte, read the status byte, and write a byte. A write first polls the status byte until the target is no longer writing, then enables writing, then sends the data. Writes are refused outside the user address window. The DAC command leaves the EEPROM select low, shifts its 12 bits and pulses a load strobe. Every clock phase lasts `PHASE_CYCLES` system clocks. The default of 125 gives 1 µs at a 125 MHz system clock.

Top module: `serial_cal_top`

## Requirements
- R1: Every outgoing field is sent most significant bit first. For each bit, `sclk` is low for `PHASE_CYCLES` clocks with `sdo` holding the bit, then high for `PHASE_CYCLES` clocks with `sdo` unchanged. `sclk` is low whenever no bit is being moved.
- R2: For each incoming bit, `sclk` is high for one phase and then low for one phase. `eeSdi` is sampled at the end of the low phase. Eight bits are collected, first bit into the MSB.
- R3: Command `cmdOp`=0 (read) sends instruction 0x03 and then address `cmdAddr`. It then shifts in 8 bits, and these appear on `rdData` when busy falls.
- R4: Command `cmdOp`=2 (status) sends instruction 0x05 and shifts in 8 bits to `rdData`. Bit 0 of that byte set means a write is in progress.
- R5: Command `cmdOp`=1 (write) first runs status transactions, each framed by its own `eeEn` pulse, until bit 0 reads clear. After `POLL_LIMIT` attempts that all read set, it stops, raises `err` and sends no write.
- R6: Once the target is idle, the write sends instruction 0x06 in its own `eeEn` frame, drops `eeEn` for one phase, then sends 0x02, the address and the `cmdData` byte in one frame. `wrUnprot` is high from the 0x06 frame to the end of the data.
- R7: A write whose address is below 16 or above 127 is refused. `err` rises the next cycle, `busy` stays low, and `sclk` does not toggle.
- R8: Command `cmdOp`=3 (DAC) keeps `eeEn` and `wrUnprot` low. It shifts `cmdAddr[3:0]` and then `cmdData`, 12 bits in total, and then holds `dacLoad` high for one phase and low again.
- R9: Every transaction ends with one phase in which `eeEn`, `wrUnprot`, `dacLoad` and `sclk` are all low before `busy` falls. While `busy` is low, all four stay low.
- R10: `busy` rises the cycle after a command is accepted and stays high until the final release phase ends. `cmdValid` while `busy` is high has no effect.
- R11: `err` is cleared when a command is accepted and reflects only the most recent command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 2 | 0 read, 1 write, 2 status, 3 DAC |
| cmdAddr | input | 8 | EEPROM address, or DAC channel in bits 3:0 |
| cmdData | input | 8 | Byte to write or DAC value |
| eeSdi | input | 1 | Serial output of the EEPROM |
| busy | output | 1 | Command in progress |
| err | output | 1 | Last command refused or timed out |
| rdData | output | 8 | Byte from the last read or status command |
| sclk | output | 1 | Shared serial clock |
| sdo | output | 1 | Shared serial data to the targets |
| eeEn | output | 1 | EEPROM select, active high |
| wrUnprot | output | 1 | EEPROM write unprotect |
| dacLoad | output | 1 | DAC load strobe |

## Verification
The assertions assume that `cmdAddr` and `cmdOp` are known in any cycle where `cmdValid` is high. They also assume that `eeSdi` has settled by the end of each low clock phase, since the sample is taken there. The bench drives every input on the falling system clock edge. Its EEPROM responder changes `eeSdi` only just after a rising serial clock, so there is a full phase of settling before the block samples. Commands are issued with a one-cycle strobe. The only strobe raised during `busy` is the one that checks that such a strobe is ignored.

// File: rtl/serial_cal_pkg.sv
package serial_cal_pkg;
  localparam int FRAME_W = 24;
  localparam int LEN_W   = 5;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_STATUS = 2'd2, OP_DAC = 2'd3} op_e;
  typedef enum logic [1:0] {XF_TX = 2'd0, XF_RX = 2'd1, XF_WAIT = 2'd2} xfer_e;

  typedef struct packed {
    logic               start;
    xfer_e              kind;
    logic [LEN_W-1:0]   len;
    logic [FRAME_W-1:0] word;
  } strobe_t;
endpackage

// File: rtl/serial_cal_shift.sv
module serial_cal_shift
  import serial_cal_pkg::*;
#(
  parameter int PHASE_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    stb,
  input  logic       eeSdi,
  output logic       done,
  output logic [7:0] rxByte,
  output logic       sclk,
  output logic       sdo
);
  localparam int CNT_W = $clog2(PHASE_CYCLES + 1);

  logic               active;
  logic               half;
  xfer_e              kindQ;
  logic [CNT_W-1:0]   phaseCnt;
  logic [LEN_W-1:0]   bitsLeft;
  logic [FRAME_W-1:0] shReg;
  logic               phaseEnd;

  assign phaseEnd = active && (phaseCnt == CNT_W'(PHASE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      half     <= 1'b0;
      kindQ    <= XF_WAIT;
      phaseCnt <= '0;
      bitsLeft <= '0;
      shReg    <= '0;
      rxByte   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.start && !active) begin
        active   <= 1'b1;
        kindQ    <= stb.kind;
        half     <= 1'b0;
        phaseCnt <= '0;
        bitsLeft <= stb.len;
        shReg    <= stb.word << (LEN_W'(FRAME_W) - stb.len);
      end else if (active) begin
        if (phaseEnd) begin
          phaseCnt <= '0;
          if (kindQ == XF_WAIT) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else if (!half) begin
            half <= 1'b1;
          end else begin
            half     <= 1'b0;
            bitsLeft <= bitsLeft - 1'b1;
            if (kindQ == XF_TX) shReg  <= shReg << 1;
            if (kindQ == XF_RX) rxByte <= {rxByte[6:0], eeSdi};
            if (bitsLeft == LEN_W'(1)) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
    end
  end

  assign sclk = active && (kindQ != XF_WAIT) && ((kindQ == XF_TX) ? half : !half);
  assign sdo  = active && (kindQ == XF_TX) && shReg[FRAME_W-1];

  // R1: data is already settled when the target sees the rising edge
  a_r1_data_setup: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk) && kindQ == XF_TX) |-> $stable(sdo));
  // R2: a receive frame always collects exactly one byte
  a_r2_rx_byte: assert property (@(posedge clk) disable iff (rst)
    ($rose(active) && kindQ == XF_RX) |-> bitsLeft == LEN_W'(8));
endmodule

// File: rtl/serial_cal_ctrl.sv
module serial_cal_ctrl
  import serial_cal_pkg::*;
#(
  parameter int POLL_LIMIT = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [7:0] cmdAddr,
  input  logic [7:0] cmdData,
  input  logic       done,
  input  logic [7:0] rxByte,
  output strobe_t    stb,
  output logic       busy,
  output logic       err,
  output logic [7:0] rdData,
  output logic       eeEn,
  output logic       wrUnprot,
  output logic       dacLoad
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_TX, S_RD_RX, S_ST_TX, S_ST_RX, S_PL_TX, S_PL_RX, S_PL_GAP,
    S_WE_TX, S_WE_GAP, S_WR_TX, S_DAC_TX, S_DAC_LD, S_FIN
  } state_e;

  state_e            state;
  logic              launch;
  logic [7:0]        addrQ, dataQ;
  logic [POLL_W-1:0] polls;
  logic              wipQ;
  logic              reject;

  assign reject = (op_e'(cmdOp) == OP_WRITE) && (cmdAddr[7] || cmdAddr < 8'd16);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      launch <= 1'b0;
      err    <= 1'b0;
      rdData <= '0;
      addrQ  <= '0;
      dataQ  <= '0;
      polls  <= '0;
      wipQ   <= 1'b0;
    end else begin
      launch <= 1'b0;
      if (state == S_IDLE) begin
        if (cmdValid) begin
          addrQ <= cmdAddr;
          dataQ <= cmdData;
          polls <= '0;
          if (reject) begin
            err <= 1'b1;
          end else begin
            err    <= 1'b0;
            launch <= 1'b1;
            case (op_e'(cmdOp))
              OP_READ:   state <= S_RD_TX;
              OP_STATUS: state <= S_ST_TX;
              OP_WRITE:  state <= S_PL_TX;
              default:   state <= S_DAC_TX;
            endcase
          end
        end
      end else if (done) begin
        launch <= 1'b1;
        case (state)
          S_RD_TX:  state <= S_RD_RX;
          S_RD_RX:  begin rdData <= rxByte; state <= S_FIN; end
          S_ST_TX:  state <= S_ST_RX;
          S_ST_RX:  begin rdData <= rxByte; state <= S_FIN; end
          S_PL_TX:  state <= S_PL_RX;
          S_PL_RX:  begin wipQ <= rxByte[0]; polls <= polls + 1'b1; state <= S_PL_GAP; end
          S_PL_GAP: begin
            if (!wipQ) state <= S_WE_TX;
            else if (polls == POLL_W'(POLL_LIMIT)) begin err <= 1'b1; state <= S_FIN; end
            else state <= S_PL_TX;
          end
          S_WE_TX:  state <= S_WE_GAP;
          S_WE_GAP: state <= S_WR_TX;
          S_WR_TX:  state <= S_FIN;
          S_DAC_TX: state <= S_DAC_LD;
          S_DAC_LD: state <= S_FIN;
          default:  begin launch <= 1'b0; state <= S_IDLE; end
        endcase
      end
    end
  end

  always_comb begin
    stb       = '0;
    stb.start = launch;
    stb.kind  = XF_WAIT;
    case (state)
      S_RD_TX:  begin stb.kind = XF_TX; stb.len = LEN_W'(16); stb.word = {8'h00, 8'h03, addrQ}; end
      S_ST_TX, S_PL_TX:
                begin stb.kind = XF_TX; stb.len = LEN_W'(8);  stb.word = {16'h0000, 8'h05}; end
      S_RD_RX, S_ST_RX, S_PL_RX:
                begin stb.kind = XF_RX; stb.len = LEN_W'(8); end
      S_WE_TX:  begin stb.kind = XF_TX; stb.len = LEN_W'(8);  stb.word = {16'h0000, 8'h06}; end
      S_WR_TX:  begin stb.kind = XF_TX; stb.len = LEN_W'(24); stb.word = {8'h02, addrQ, dataQ}; end
      S_DAC_TX: begin stb.kind = XF_TX; stb.len = LEN_W'(12); stb.word = {12'h000, addrQ[3:0], dataQ}; end
      default:  stb.kind = XF_WAIT;
    endcase
  end

  assign busy     = (state != S_IDLE);
  assign eeEn     = (state inside {S_RD_TX, S_RD_RX, S_ST_TX, S_ST_RX, S_PL_TX, S_PL_RX, S_WE_TX, S_WR_TX});
  assign wrUnprot = (state inside {S_WE_TX, S_WE_GAP, S_WR_TX});
  assign dacLoad  = (state == S_DAC_LD);

  // R7: an out-of-window write is refused with no transaction
  a_r7_reject: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !busy && cmdOp == 2'd1 && (cmdAddr < 8'd16 || cmdAddr > 8'd127)) |=> (!busy && err));
  // R8: the DAC strobe never overlaps the EEPROM select lines
  a_r8_dac_excl: assert property (@(posedge clk) disable iff (rst)
    dacLoad |-> (!eeEn && !wrUnprot));
  // R9: lines are released when busy ends
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!eeEn && !wrUnprot && !dacLoad));
  // R11: an accepted command clears the error flag
  a_r11_err_clear: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && !busy && !(cmdOp == 2'd1 && (cmdAddr < 8'd16 || cmdAddr > 8'd127))) |=> (busy && !err));
endmodule

// File: rtl/serial_cal_top.sv
module serial_cal_top
  import serial_cal_pkg::*;
#(
  parameter int PHASE_CYCLES = 125,
  parameter int POLL_LIMIT   = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [7:0] cmdAddr,
  input  logic [7:0] cmdData,
  input  logic       eeSdi,
  output logic       busy,
  output logic       err,
  output logic [7:0] rdData,
  output logic       sclk,
  output logic       sdo,
  output logic       eeEn,
  output logic       wrUnprot,
  output logic       dacLoad
);
  strobe_t    stb;
  logic       done;
  logic [7:0] rxByte;

  serial_cal_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .done(done), .rxByte(rxByte), .stb(stb), .busy(busy),
    .err(err), .rdData(rdData), .eeEn(eeEn), .wrUnprot(wrUnprot), .dacLoad(dacLoad)
  );

  serial_cal_shift #(.PHASE_CYCLES(PHASE_CYCLES)) u_shift (
    .clk(clk), .rst(rst), .stb(stb), .eeSdi(eeSdi), .done(done),
    .rxByte(rxByte), .sclk(sclk), .sdo(sdo)
  );

  // R10: the serial clock only moves inside a command
  a_r10_sclk_busy: assert property (@(posedge clk) disable iff (rst)
    sclk |-> busy);
endmodule

// File: tb/sim_serial_cal_top.sv
module sim_serial_cal_top;
  localparam int PH   = 4;
  localparam int POLL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdAddr = 8'd0, cmdData = 8'd0;
  logic eeSdi = 1'b0;
  logic busy, err, sclk, sdo, eeEn, wrUnprot, dacLoad;
  logic [7:0] rdData;

  always #4 clk = ~clk;

  serial_cal_top #(.PHASE_CYCLES(PH), .POLL_LIMIT(POLL)) u0 (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .eeSdi(eeSdi), .busy(busy), .err(err), .rdData(rdData),
    .sclk(sclk), .sdo(sdo), .eeEn(eeEn), .wrUnprot(wrUnprot), .dacLoad(dacLoad)
  );

  int tests = 0, fails = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural targets
  logic [7:0] mem [256];
  logic [7:0] dacReg [16];
  int  wipPolls = 0, statusReads = 0, sclkRises = 0, dacLoads = 0, writesSeen = 0;
  int  eeBits = 0, dacBits = 0, dacBitsAtLoad = 0;
  logic [23:0] eeIn = '0;
  logic [11:0] dacSh = '0;
  logic [7:0] eeInstr = '0, outByte = '0;
  bit  outActive = 0, wel = 0, wpAtWrite = 0;
  logic prevEn = 0, prevSclk = 0, prevLoad = 0;
  int  highRun = 0, widthErr = 0, idleErr = 0, overlapErr = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst) begin
      if (eeEn && !prevEn) begin eeBits = 0; eeInstr = '0; outActive = 0; end
      if (!eeEn && prevEn) begin
        if (eeInstr == 8'h06) wel = 1;
        if (eeInstr == 8'h02 && eeBits >= 24) begin
          writesSeen++;
          if (wel && wpAtWrite) mem[eeIn[15:8]] = eeIn[7:0];
          wel = 0;
        end
      end
      if (sclk && !prevSclk) begin
        sclkRises++;
        if (eeEn) begin
          if (outActive) begin
            eeSdi <= outByte[7];
            outByte = {outByte[6:0], 1'b0};
          end else begin
            eeIn = {eeIn[22:0], sdo};
            eeBits++;
            if (eeBits == 8) begin
              eeInstr = eeIn[7:0];
              if (eeInstr == 8'h05) begin
                outActive = 1;
                outByte = {7'd0, wipPolls > 0};
                statusReads++;
                if (wipPolls > 0) wipPolls--;
              end
            end
            if (eeBits == 16 && eeInstr == 8'h03) begin outActive = 1; outByte = mem[eeIn[7:0]]; end
            if (eeBits == 24 && eeInstr == 8'h02) wpAtWrite = wrUnprot;
          end
        end else begin
          dacSh = {dacSh[10:0], sdo};
          dacBits++;
        end
      end
      if (dacLoad && !prevLoad) begin
        dacReg[dacSh[11:8]] = dacSh[7:0];
        dacLoads++;
        dacBitsAtLoad = dacBits;
        dacBits = 0;
      end
      // per-clock monitors
      if (sclk) highRun++;
      else if (prevSclk) begin
        if (highRun != PH) widthErr++;
        highRun = 0;
      end
      if (!busy && (sclk || eeEn || wrUnprot || dacLoad)) idleErr++;
      if (dacLoad && (eeEn || wrUnprot)) overlapErr++;
    end
    prevEn = eeEn; prevSclk = sclk; prevLoad = dacLoad;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 16; i++) dacReg[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset busy", busy, 0);
    check("R11 reset err", err, 0);
    check("R9 reset lines", {sclk, eeEn, wrUnprot, dacLoad}, 0);

    // R3 / R2 reads
    issue(2'd0, 8'h20, 8'h00);
    check("R2 R3 read 0x20", rdData, mem[8'h20]);
    issue(2'd0, 8'hC5, 8'h00);
    check("R2 R3 read 0xC5", rdData, mem[8'hC5]);

    // R4 status
    wipPolls = 0;
    issue(2'd2, 8'h00, 8'h00);
    check("R4 status idle", rdData, 0);
    wipPolls = 1;
    issue(2'd2, 8'h00, 8'h00);
    check("R4 status write in progress", rdData, 1);

    // R5 / R6 write at low edge of window with busy target
    begin
      int s0;
      wipPolls = 3;
      s0 = statusReads;
      issue(2'd1, 8'd16, 8'h5A);
      check("R5 poll count", statusReads - s0, 4);
      check("R11 write err", err, 0);
      check("R6 write stored", mem[16], 8'h5A);
      check("R6 unprotect during data", wpAtWrite, 1);
      check("R9 lines released", {eeEn, wrUnprot}, 0);
      issue(2'd0, 8'd16, 8'h00);
      check("R3 readback 16", rdData, 8'h5A);
      s0 = statusReads;
      issue(2'd1, 8'd127, 8'hC3);
      check("R5 single poll", statusReads - s0, 1);
      check("R6 write at 127", mem[127], 8'hC3);
    end

    // R7 refused addresses
    begin
      int r0;
      logic [7:0] keep;
      keep = mem[15];
      r0 = sclkRises;
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = 2'd1; cmdAddr = 8'd15; cmdData = 8'hEE;
      @(negedge clk);
      cmdValid = 1'b0;
      check("R7 busy stays low", busy, 0);
      check("R7 err raised", err, 1);
      repeat (20) @(negedge clk);
      issue(2'd1, 8'd128, 8'hEE);
      check("R7 err at 128", err, 1);
      check("R7 no bus activity", sclkRises - r0, 0);
      issue(2'd0, 8'd15, 8'h00);
      check("R7 address 15 unchanged", rdData, keep);
      check("R11 err cleared", err, 0);
    end

    // R5 timeout
    begin
      int s0, w0;
      logic [7:0] keep;
      keep = mem[50];
      wipPolls = 1000;
      s0 = statusReads; w0 = writesSeen;
      issue(2'd1, 8'd50, 8'h11);
      check("R5 timeout err", err, 1);
      check("R5 timeout attempts", statusReads - s0, POLL);
      check("R5 no write frame", writesSeen - w0, 0);
      wipPolls = 0;
      issue(2'd0, 8'd50, 8'h00);
      check("R5 data unchanged", rdData, keep);
    end

    // R8 DAC writes
    issue(2'd3, 8'h05, 8'hA5);
    check("R8 dac ch5", dacReg[5], 8'hA5);
    check("R8 dac frame bits", dacBitsAtLoad, 12);
    issue(2'd3, 8'hFF, 8'h3C);
    check("R8 dac ch15", dacReg[15], 8'h3C);

    // R10 command during busy ignored
    begin
      int l0;
      l0 = dacLoads;
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = 2'd0; cmdAddr = 8'd3; cmdData = 8'h00;
      @(negedge clk);
      cmdValid = 1'b0;
      check("R10 busy after accept", busy, 1);
      repeat (10) @(negedge clk);
      cmdValid = 1'b1; cmdOp = 2'd3; cmdAddr = 8'd2; cmdData = 8'h77;
      @(negedge clk);
      cmdValid = 1'b0;
      while (busy) @(negedge clk);
      repeat (4 * PH + 4) @(negedge clk);
      check("R10 ignored dac", dacReg[2], 0);
      check("R10 no extra load", dacLoads - l0, 0);
      check("R10 read intact", rdData, mem[3]);
    end

    check("R1 clock high width", widthErr, 0);
    check("R9 idle lines", idleErr, 0);
    check("R8 no overlap", overlapErr, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule